// File: doc/BRIEF.md
# Serial Mode-Control Register Port

This block is a four-wire serial slave that gives a host access to a small file of 8-bit mode-control registers. The host pulls a select line low, clocks a 16-bit command word in MSB first, and raises the select line again. A write puts the data byte into the register that the command names. A read ignores the command's address field. It fetches the byte at the address held in a dedicated pointer register, and shifts that byte back out on the serial output during the second half of the same frame.

The pointer register also carries an auto-increment enable, so the host can walk through the file with a run of read frames. All serial inputs are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. The serial output comes with a separate enable, which the pad ring uses to tri-state the pin. The register contents are exported as one flat vector for the rest of the chip.

Top module: `ctrl_serial_port`

## Requirements
- R1: A frame is 16 bits, sampled on rising serial-clock edges, MSB first. Bit 15 is the direction flag (0 = write, 1 = read), bits 14:8 are a 7-bit register index, and bits 7:0 are the data byte.
- R2: On a write frame, the data byte is stored into the indexed register only when the select line rises after exactly 16 rising serial-clock edges. Register i appears on `regs_o[8*i+7:8*i]`.
- R3: A frame ended by the select line rising after fewer or more than 16 clocks changes no register and does not move the read pointer.
- R4: A write to an index at or above N_REGS (default 16) changes nothing.
- R5: A read frame takes its target from bits 6:0 of register 11 and ignores the frame's index bits.
- R6: `sdo_oe_o` is low while the select line is high and during the first 8 clocks of every frame. It is high during the last 8 clocks of a read frame only.
- R7: During a read frame, the output data changes after falling serial-clock edges. The byte is presented MSB first, so the host samples bit 7 at the 9th rising edge and bit 0 at the 16th.
- R8: A read whose pointer is at or above N_REGS returns 0x00.
- R9: Bit 7 of register 11 enables auto-increment. When it is 1, each completed read frame adds one to the 7-bit pointer, which wraps from 127 to 0. When it is 0, the pointer stays where it is.
- R10: The asynchronous reset clears every register to 0x00 and turns the output driver off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_i | input | 1 | Frame select, idles high, low during a frame |
| sclk_i | input | 1 | Host serial clock, idle low |
| sdi_i | input | 1 | Serial command data in |
| sdo_o | output | 1 | Serial readback data |
| sdo_oe_o | output | 1 | Drive enable for the serial output pad |
| regs_o | output | N_REGS*8 | Flat register contents |

## Verification
The end of a read frame has two effects that land on the same system-clock edge: the frame commits, and the pointer auto-increments. When register 11 reads itself, the byte shifted out must therefore be the pointer value from before the increment. The bench provokes this with directed reads of register 11 while auto-increment is on. It judges the returned byte against the old pointer and checks the new pointer on `regs_o`. Randomised frames mix writes to the pointer register with reads, truncated frames and overlong frames, and every result is compared against a bench model of the register file.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 5;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/cp_sync2.sv
module cp_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cp_frame_rx.sv
module cp_frame_rx
  import ctrl_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lat_s_i,
  input  logic             lat_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sdi_s_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rd_o,
  output frame_t           frame_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] SAT  = '1;

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
      rd_q  <= 1'b0;
    end else if (lat_s_i) begin
      cnt_q <= '0;
    end else if (sclk_rise_i) begin
      if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < FULL) sr_q <= {sr_q[FRAME_W-2:0], sdi_s_i};
      if (cnt_q == '0)  rd_q <= sdi_s_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign rd_o    = rd_q;
  assign frame_o = frame_t'(sr_q);
  // commit only for an exact-length frame
  assign done_o  = lat_rise_i && (cnt_q == FULL);

  assert_cnt_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_s_i |=> cnt_q == '0);
  assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lat_s_i && !sclk_rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cp_regfile.sv
module cp_regfile
  import ctrl_port_pkg::*;
#(
  parameter int N_REGS   = 16,
  parameter int RIDX_REG = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   done_i,
  input  frame_t                 frame_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [N_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] regs_q [N_REGS];
  logic [ADDR_W-1:0] ptr;
  logic              wr_en, rd_done;

  assign wr_en   = done_i && !frame_i.rd;
  assign rd_done = done_i && frame_i.rd;
  assign ptr     = regs_q[RIDX_REG][ADDR_W-1:0];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    if (g == RIDX_REG) begin : g_ptr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (wr_en && frame_i.idx == ADDR_W'(g)) regs_q[g] <= frame_i.data;
        else if (rd_done && regs_q[g][DATA_W-1])
          regs_q[g][ADDR_W-1:0] <= regs_q[g][ADDR_W-1:0] + 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else if (wr_en && frame_i.idx == ADDR_W'(g)) regs_q[g] <= frame_i.data;
      end
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_REGS; i++)
      if (ptr == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  assert_autoinc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done && regs_q[RIDX_REG][DATA_W-1]) |=> ptr == $past(ptr) + 1'b1);
  assert_noinc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done && !regs_q[RIDX_REG][DATA_W-1]) |=> $stable(regs_o));
  assert_unimpl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && int'(frame_i.idx) >= N_REGS) |=> $stable(regs_o));
  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(regs_o));
endmodule

// File: rtl/cp_sdo_drv.sv
module cp_sdo_drv
  import ctrl_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_s_i,
  input  logic              sclk_fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(FRAME_W / 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [DATA_W-1:0] sh_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (lat_s_i) begin
      oe_q <= 1'b0;
    end else if (sclk_fall_i) begin
      if (rd_i && cnt_i == HALF) begin
        sh_q <= rdata_i;
        oe_q <= 1'b1;
      end else if (oe_q && cnt_i < FULL) begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_o = oe_q & sh_q[DATA_W-1];
  assign oe_o  = oe_q;

  assert_oe_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_s_i |=> !oe_q);
  assert_oe_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> rd_i);
  assert_oe_late_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> cnt_i == HALF);
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port
  import ctrl_port_pkg::*;
#(
  parameter int N_REGS   = 16,
  parameter int RIDX_REG = 11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     latch_i,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  output logic                     sdo_oe_o,
  output logic [N_REGS*DATA_W-1:0] regs_o
);
  logic [2:0]        sync_q;
  logic              lat_s, sclk_s, sdi_s, lat_q, sclk_q;
  logic              lat_rise, sclk_rise, sclk_fall;
  logic [CNT_W-1:0]  cnt;
  logic              rd, done;
  frame_t            frame;
  logic [DATA_W-1:0] rdata;

  cp_sync2 #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({latch_i, sclk_i, sdi_i}), .q_o(sync_q)
  );
  assign {lat_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      lat_q  <= lat_s;
      sclk_q <= sclk_s;
    end
  end

  assign lat_rise  = lat_s & ~lat_q;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  cp_frame_rx u_rx (
    .clk_i, .rst_ni, .lat_s_i(lat_s), .lat_rise_i(lat_rise),
    .sclk_rise_i(sclk_rise), .sdi_s_i(sdi_s),
    .cnt_o(cnt), .rd_o(rd), .frame_o(frame), .done_o(done)
  );

  cp_regfile #(.N_REGS(N_REGS), .RIDX_REG(RIDX_REG)) u_rf (
    .clk_i, .rst_ni, .done_i(done), .frame_i(frame),
    .rdata_o(rdata), .regs_o(regs_o)
  );

  cp_sdo_drv u_drv (
    .clk_i, .rst_ni, .lat_s_i(lat_s), .sclk_fall_i(sclk_fall),
    .cnt_i(cnt), .rd_i(rd), .rdata_i(rdata), .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  initial begin
    assert_cfg_R5: assert (RIDX_REG < N_REGS && N_REGS <= 128);
  end
endmodule

// File: tb/ctrl_serial_port_test.sv
module ctrl_serial_port_test;
  localparam int N    = 16;
  localparam int RIDX = 11;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic latch = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [N*8-1:0] regs;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] m [N];

  always #10 clk = ~clk;

  ctrl_serial_port #(.N_REGS(N), .RIDX_REG(RIDX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .latch_i(latch), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .regs_o(regs)
  );

  function automatic logic [N*8-1:0] model_vec();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = m[i];
    return v;
  endfunction

  function automatic logic [7:0] model_read();
    int p = int'(m[RIDX][6:0]);
    return (p < N) ? m[p] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one frame of nclk clocks; returns readback byte and count of bad enable samples
  task automatic xfer(input logic [15:0] w, input int nclk, output logic [7:0] rb, output int oe_bad);
    rb = '0;
    oe_bad = 0;
    @(negedge clk);
    latch = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 8) rb = {rb[6:0], sdo};
      if (nclk == 16 && sdo_oe !== (w[15] && i >= 8)) oe_bad++;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    latch = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input int idx, input logic [7:0] d, input int nclk);
    logic [7:0] rb;
    int bad;
    xfer({1'b0, 7'(idx), d}, nclk, rb, bad);
    if (nclk == 16 && idx < N) m[idx] = d;
    chk(nclk == 16 ? (idx < N ? "R2 write" : "R4 unimpl write") : "R3 bad length",
        128'(regs), 128'(model_vec()));
    chk("R6 enable off after write", 128'(sdo_oe), 128'(0));
  endtask

  task automatic do_read(input logic [6:0] junk_idx);
    logic [7:0] rb, exp;
    int bad;
    exp = model_read();
    xfer({1'b1, junk_idx, 8'h00}, 16, rb, bad);
    if (m[RIDX][7]) m[RIDX][6:0] = m[RIDX][6:0] + 7'd1;
    chk(int'(m[RIDX][6:0]) >= N ? "R8 unimpl read" : "R5 R7 read data", 128'(rb), 128'(exp));
    chk("R6 enable window", 128'(bad), 128'(0));
    chk("R9 pointer after read", 128'(regs), 128'(model_vec()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 reset regs", 128'(regs), 128'(0));
    chk("R10 reset enable", 128'(sdo_oe), 128'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: R2 write, R5 read ignoring frame index, R7 bit order
    do_write(3, 8'hA5, 16);
    do_write(RIDX, 8'h03, 16);
    do_read(7'h55);
    // R3 short and long frames
    do_write(4, 8'h77, 15);
    do_write(4, 8'h77, 17);
    do_write(4, 8'h01, 3);
    // R4 unimplemented index
    do_write(16, 8'hFF, 16);
    do_write(127, 8'hFF, 16);
    // R9 auto-increment off: pointer stays
    do_read(7'h00);
    do_read(7'h00);
    // R9 auto-increment on, walking 3 -> 4 -> 5
    do_write(4, 8'h3C, 16);
    do_write(RIDX, 8'h83, 16);
    do_read(7'h00);
    do_read(7'h00);
    // pointer reads itself: old value out, increment lands at frame end
    do_write(RIDX, 8'h8B, 16);
    do_read(7'h00);
    // R9 wrap 127 -> 0, R8 unimplemented read returns zero
    do_write(0, 8'h5E, 16);
    do_write(RIDX, 8'hFF, 16);
    do_read(7'h00);
    do_read(7'h00);

    // random mix
    for (int k = 0; k < 60; k++) begin
      int op = int'($urandom % 5);
      case (op)
        0, 1: do_write(int'($urandom % 20), 8'($urandom), 16);
        2: do_write(RIDX, {1'($urandom), 7'($urandom % 20)}, 16);
        3: do_read(7'($urandom));
        default: do_write(int'($urandom % N), 8'($urandom),
                          ($urandom % 2) ? int'($urandom % 15) + 1 : 17 + int'($urandom % 3));
      endcase
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule